// File: doc/BRIEF.md
# Load-Load Ordering Guard Queue

This block tracks in-flight loads for a core that executes loads out of order and lets one load take its value from memory before an older load has done so. Each load gets a slot when it is dispatched, in program order, and the slot takes the load's address when the load is bound to its value. While an older load is still unbound, a bound load stays exposed to reordering. During that window every coherence invalidation or external store that the core snoops is compared with it. A match means another agent may have written the location between the two bindings, so the block raises a restart request that names the load. The core then discards that load and everything younger and executes again from that load.

A bound load is no longer watched as soon as every load older than it has also been bound. This can happen well before the load retires, and it releases it from the snoop compare. Slots are freed at retirement from the head of the queue. The core can also cut the queue back to any tag after a mispredict. Loads to non-coherent memory cannot be protected by snooping, so they are flagged at dispatch and only bind when they are the oldest load in the queue. The queue holds 16 slots. The 4-bit tag is the slot index, and all age decisions are measured from the head pointer, so they stay correct when tags wrap.

Top module: `ldord_guard`

## Requirements
- R1: After reset the queue is empty: `alloc_tag` is 0, `q_full` is 0 and `nuke_valid` is 0.
- R2: Each accepted allocation takes the tag shown on `alloc_tag`, and `alloc_tag` then advances by one modulo 16, so tags follow program order.
- R3: With 16 loads held, `q_full` is 1 and a further allocation is ignored: `alloc_tag` does not change.
- R4: A snoop whose line matches a bound, coherent load that has an older unbound load raises `nuke_valid` for one cycle on the next clock edge, with `nuke_tag` set to that load's tag.
- R5: Addresses are compared as 64-byte lines: bits [ADDR_W-1:6] must be equal, and bits [5:0] are ignored.
- R6: A bound load that has no older unbound load is not watched, and a matching snoop raises no restart. The oldest load is never watched.
- R7: A load that has not yet been bound never matches a snoop.
- R8: When several watched loads match one snoop, `nuke_tag` is the oldest of them, with age counted from the head of the queue. This holds across the 15-to-0 tag wrap.
- R9: In the same edge that raises `nuke_valid`, the restart load and all younger loads are removed, so `alloc_tag` equals `nuke_tag` while `nuke_valid` is high.
- R10: A load allocated with `alloc_nc` = 1 is non-coherent. A bind to it is ignored unless it is the oldest load, so while it is unbound, younger bound loads remain watched.
- R11: `retire_valid` frees the oldest load, and `q_full` drops when the queue was full.
- R12: `flush_valid` removes the load at `flush_tag` and all younger loads, so `alloc_tag` equals `flush_tag` afterwards. Older loads keep their state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocate a slot for the next load in program order |
| alloc_nc | input | 1 | The allocated load targets non-coherent memory |
| alloc_tag | output | 4 | Tag the next allocation receives |
| q_full | output | 1 | All 16 slots are in use |
| bind_valid | input | 1 | A load has been bound to its value |
| bind_tag | input | 4 | Tag of the bound load |
| bind_addr | input | ADDR_W | Address of the bound load |
| snoop_valid | input | 1 | An invalidation or external store is observed |
| snoop_addr | input | ADDR_W | Address of the snooped write |
| retire_valid | input | 1 | The oldest load retires |
| flush_valid | input | 1 | Discard loads from `flush_tag` onward |
| flush_tag | input | 4 | First tag removed by a flush |
| nuke_valid | output | 1 | Restart request caused by an ordering violation |
| nuke_tag | output | 4 | Tag of the load where execution restarts |

## Verification
The assertions rely on three properties of the inputs. A retire only names a bound load at the head. A flush tag always lies inside the occupied range. A bind never targets a free slot. The bench keeps to all three by binding each load before it retires, flushing only to allocated tags and binding only tags it has allocated. Snoops and flushes arrive in separate cycles, so each restart has one cause that the bench can predict.

// File: rtl/ldord_pkg.sv
package ldord_pkg;
  // log2 of the coherence line size used for address comparison
  localparam int unsigned LINE_OFF_DEF = 6;

  typedef enum logic [1:0] {
    CUT_NONE  = 2'd0,
    CUT_NUKE  = 2'd1,
    CUT_FLUSH = 2'd2
  } cut_src_e;
endpackage

// File: rtl/ldord_slot.sv
module ldord_slot #(
  parameter int unsigned LINE_W = 34
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic              alloc_nc,
  input  logic              bind_en,
  input  logic [LINE_W-1:0] bind_line,
  input  logic [LINE_W-1:0] snoop_line,
  output logic              bound,
  output logic              nc,
  output logic              line_hit
);
  logic              bound_q, bound_d;
  logic              nc_q, nc_d;
  logic [LINE_W-1:0] line_q, line_d;

  always_comb begin
    bound_d = bound_q;
    nc_d    = nc_q;
    line_d  = line_q;
    if (alloc_en) begin
      bound_d = 1'b0;
      nc_d    = alloc_nc;
    end else if (bind_en) begin
      bound_d = 1'b1;
      line_d  = bind_line;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bound_q <= 1'b0;
      nc_q    <= 1'b0;
      line_q  <= '0;
    end else begin
      bound_q <= bound_d;
      nc_q    <= nc_d;
      line_q  <= line_d;
    end
  end

  assign bound    = bound_q;
  assign nc       = nc_q;
  assign line_hit = bound_q && (line_q == snoop_line);

  // R7: a freshly allocated slot starts unbound and so cannot match
  a_r7_fresh_unbound: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |=> !line_hit);
endmodule

// File: rtl/ldord_scan.sv
module ldord_scan #(
  parameter int unsigned TAG_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [TAG_W-1:0]      head,
  input  logic [TAG_W:0]        count,
  input  logic [(1<<TAG_W)-1:0] bound_vec,
  input  logic [(1<<TAG_W)-1:0] nc_vec,
  input  logic [(1<<TAG_W)-1:0] hit_vec,
  input  logic                  snoop_valid,
  output logic                  pick_valid,
  output logic [TAG_W-1:0]      pick_age
);
  localparam int unsigned DEPTH = 1 << TAG_W;
  localparam int unsigned CNT_W = TAG_W + 1;

  // Walk from the head toward the tail; a slot is watched while any older
  // occupied slot is still unbound. The first watched hit is the oldest.
  always_comb begin
    logic             older_unbound;
    logic             in_q;
    logic             watched;
    logic [TAG_W-1:0] idx;
    older_unbound = 1'b0;
    pick_valid    = 1'b0;
    pick_age      = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx     = head + TAG_W'(k);
      in_q    = CNT_W'(k) < count;
      watched = in_q && bound_vec[idx] && !nc_vec[idx] && older_unbound;
      if (snoop_valid && watched && hit_vec[idx] && !pick_valid) begin
        pick_valid = 1'b1;
        pick_age   = TAG_W'(k);
      end
      older_unbound = older_unbound || (in_q && !bound_vec[idx]);
    end
  end

  // R6: the head load is released, so a chosen restart is never the head
  a_r6_head_released: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> (pick_age != '0));
endmodule

// File: rtl/ldord_guard.sv
module ldord_guard #(
  parameter int unsigned TAG_W    = 4,
  parameter int unsigned ADDR_W   = 40,
  parameter int unsigned LINE_OFF = ldord_pkg::LINE_OFF_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic              alloc_nc,
  output logic [TAG_W-1:0]  alloc_tag,
  output logic              q_full,
  input  logic              bind_valid,
  input  logic [TAG_W-1:0]  bind_tag,
  input  logic [ADDR_W-1:0] bind_addr,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              retire_valid,
  input  logic              flush_valid,
  input  logic [TAG_W-1:0]  flush_tag,
  output logic              nuke_valid,
  output logic [TAG_W-1:0]  nuke_tag
);
  import ldord_pkg::*;

  localparam int unsigned DEPTH  = 1 << TAG_W;
  localparam int unsigned CNT_W  = TAG_W + 1;
  localparam int unsigned LINE_W = ADDR_W - LINE_OFF;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [TAG_W-1:0] head_q, head_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             nuke_v_q, nuke_v_d;
  logic [TAG_W-1:0] nuke_tag_q, nuke_tag_d;

  logic [DEPTH-1:0] bound_vec, nc_vec, hit_vec;
  logic             pick_valid;
  logic [TAG_W-1:0] pick_age;

  logic [TAG_W-1:0] tail_idx, flush_age, bind_age, cut_age;
  logic             alloc_ok, bind_ok, retire_ok, nuke_take;
  logic [CNT_W-1:0] base_cnt;
  cut_src_e         cut_src;

  assign tail_idx  = head_q + count_q[TAG_W-1:0];
  assign q_full    = (count_q == FULL_CNT);
  assign flush_age = flush_tag - head_q;
  assign bind_age  = bind_tag - head_q;

  // Non-coherent loads may only bind from the head slot
  assign bind_ok = bind_valid && ({1'b0, bind_age} < count_q) &&
                   (!nc_vec[bind_tag] || (bind_age == '0));

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    ldord_slot #(.LINE_W(LINE_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc_en  (alloc_ok && (tail_idx == TAG_W'(g))),
      .alloc_nc  (alloc_nc),
      .bind_en   (bind_ok && (bind_tag == TAG_W'(g))),
      .bind_line (bind_addr[ADDR_W-1:LINE_OFF]),
      .snoop_line(snoop_addr[ADDR_W-1:LINE_OFF]),
      .bound     (bound_vec[g]),
      .nc        (nc_vec[g]),
      .line_hit  (hit_vec[g])
    );
  end

  ldord_scan #(.TAG_W(TAG_W)) u_scan (
    .clk        (clk),
    .rst_n      (rst_n),
    .head       (head_q),
    .count      (count_q),
    .bound_vec  (bound_vec),
    .nc_vec     (nc_vec),
    .hit_vec    (hit_vec),
    .snoop_valid(snoop_valid),
    .pick_valid (pick_valid),
    .pick_age   (pick_age)
  );

  // Next state: the older of a snoop restart and a flush decides the cut
  always_comb begin
    nuke_take = pick_valid && !(flush_valid && (flush_age <= pick_age));
    if (nuke_take) begin
      cut_src = CUT_NUKE;
      cut_age = pick_age;
    end else if (flush_valid) begin
      cut_src = CUT_FLUSH;
      cut_age = flush_age;
    end else begin
      cut_src = CUT_NONE;
      cut_age = '0;
    end
    alloc_ok  = alloc_valid && !q_full && (cut_src == CUT_NONE);
    retire_ok = retire_valid && (count_q != '0);
    base_cnt  = (cut_src != CUT_NONE) ? {1'b0, cut_age}
                                      : count_q + CNT_W'(alloc_ok);
    count_d   = (retire_ok && (base_cnt != '0)) ? base_cnt - 1'b1 : base_cnt;
    head_d    = head_q + TAG_W'(retire_ok);
    nuke_v_d  = nuke_take;
    nuke_tag_d = nuke_take ? head_q + pick_age : nuke_tag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q     <= '0;
      count_q    <= '0;
      nuke_v_q   <= 1'b0;
      nuke_tag_q <= '0;
    end else begin
      head_q     <= head_d;
      count_q    <= count_d;
      nuke_v_q   <= nuke_v_d;
      nuke_tag_q <= nuke_tag_d;
    end
  end

  assign alloc_tag  = tail_idx;
  assign nuke_valid = nuke_v_q;
  assign nuke_tag   = nuke_tag_q;

  // R3: occupancy never exceeds the slot count
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= FULL_CNT);

  // R9: the restart load and younger are gone when the request is raised
  a_r9_tail_at_nuke: assert property (@(posedge clk) disable iff (!rst_n)
    nuke_v_q |-> (tail_idx == nuke_tag_q));

  // R2: an accepted allocation moves the tail by exactly one
  a_r2_tail_steps: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ok |=> (tail_idx == TAG_W'($past(tail_idx) + 1'b1)));

  // R11: a retire on a non-empty queue frees one slot
  a_r11_retire_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_ok && !alloc_valid && !flush_valid && !snoop_valid) |=>
      (count_q == $past(count_q) - 1'b1));
endmodule

// File: tb/tb_ldord_guard.sv
module tb_ldord_guard;
  localparam int TAG_W  = 4;
  localparam int ADDR_W = 40;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              alloc_valid, alloc_nc;
  logic [TAG_W-1:0]  alloc_tag;
  logic              q_full;
  logic              bind_valid;
  logic [TAG_W-1:0]  bind_tag;
  logic [ADDR_W-1:0] bind_addr;
  logic              snoop_valid;
  logic [ADDR_W-1:0] snoop_addr;
  logic              retire_valid, flush_valid;
  logic [TAG_W-1:0]  flush_tag;
  logic              nuke_valid;
  logic [TAG_W-1:0]  nuke_tag;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  ldord_guard #(.TAG_W(TAG_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_nc(alloc_nc), .alloc_tag(alloc_tag),
    .q_full(q_full),
    .bind_valid(bind_valid), .bind_tag(bind_tag), .bind_addr(bind_addr),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .retire_valid(retire_valid),
    .flush_valid(flush_valid), .flush_tag(flush_tag),
    .nuke_valid(nuke_valid), .nuke_tag(nuke_tag)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // All stimulus tasks start and end on a falling edge
  task automatic do_reset();
    rst_n = 1'b0;
    alloc_valid = 0; alloc_nc = 0; bind_valid = 0; bind_tag = '0;
    bind_addr = '0; snoop_valid = 0; snoop_addr = '0; retire_valid = 0;
    flush_valid = 0; flush_tag = '0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_alloc(input logic nc);
    alloc_valid = 1'b1; alloc_nc = nc;
    @(negedge clk);
    alloc_valid = 1'b0; alloc_nc = 1'b0;
  endtask

  task automatic do_bind(input int tag, input logic [ADDR_W-1:0] a);
    bind_valid = 1'b1; bind_tag = TAG_W'(tag); bind_addr = a;
    @(negedge clk);
    bind_valid = 1'b0;
  endtask

  task automatic do_retire();
    retire_valid = 1'b1;
    @(negedge clk);
    retire_valid = 1'b0;
  endtask

  task automatic do_flush(input int tag);
    flush_valid = 1'b1; flush_tag = TAG_W'(tag);
    @(negedge clk);
    flush_valid = 1'b0;
  endtask

  // Drives one snoop cycle; nuke outputs are valid at the following negedge
  task automatic do_snoop(input logic [ADDR_W-1:0] a);
    snoop_valid = 1'b1; snoop_addr = a;
    @(negedge clk);
    snoop_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 alloc_tag", alloc_tag, 0);
    check("R1 q_full", q_full, 0);
    check("R1 nuke_valid", nuke_valid, 0);
  endtask

  task automatic t_basic_nuke();
    do_reset();
    do_alloc(0); do_alloc(0); do_alloc(0); do_alloc(0); do_alloc(0);
    check("R2 alloc_tag after five", alloc_tag, 5);
    do_bind(2, 40'h1040);
    do_snoop(40'h107F);
    check("R4 R5 nuke_valid same line", nuke_valid, 1);
    check("R4 nuke_tag", nuke_tag, 2);
    check("R9 younger discarded", alloc_tag, 2);
    @(negedge clk);
    check("R4 single pulse", nuke_valid, 0);
  endtask

  task automatic t_line_miss();
    do_reset();
    do_alloc(0); do_alloc(0); do_alloc(0);
    do_snoop(40'h3000);
    check("R7 unbound load ignores snoop", nuke_valid, 0);
    do_bind(2, 40'h3000);
    do_snoop(40'h3040);
    check("R5 next line no hit", nuke_valid, 0);
    do_snoop(40'h1003000);
    check("R5 high bits differ no hit", nuke_valid, 0);
    do_snoop(40'h303C);
    check("R5 offset ignored hit", nuke_valid, 1);
  endtask

  task automatic t_release();
    do_reset();
    do_alloc(0); do_alloc(0); do_alloc(0);
    do_bind(1, 40'h5000);
    do_bind(0, 40'h6000);
    do_snoop(40'h5000);
    check("R6 released after older bound", nuke_valid, 0);
    do_snoop(40'h6000);
    check("R6 oldest never watched", nuke_valid, 0);
    do_bind(2, 40'h7000);
    do_snoop(40'h7000);
    check("R6 bound with all older bound", nuke_valid, 0);
    check("R6 queue intact", alloc_tag, 3);
  endtask

  task automatic t_wrap_oldest();
    do_reset();
    for (int k = 0; k < 14; k++) begin
      do_alloc(0);
      do_bind(k, 40'h100);
      do_retire();
    end
    check("R11 head advanced, tail", alloc_tag, 14);
    do_alloc(0); do_alloc(0); do_alloc(0); do_alloc(0); do_alloc(0);
    check("R2 wrap tag", alloc_tag, 3);
    do_bind(2, 40'h9000);
    do_bind(1, 40'h9000);
    do_bind(15, 40'h9010);
    do_snoop(40'h9000);
    check("R8 nuke_valid multi", nuke_valid, 1);
    check("R8 oldest across wrap", nuke_tag, 15);
    check("R9 cut at restart", alloc_tag, 15);
  endtask

  task automatic t_full();
    do_reset();
    for (int k = 0; k < 16; k++) do_alloc(0);
    check("R3 q_full", q_full, 1);
    check("R3 tail wrapped", alloc_tag, 0);
    do_alloc(0);
    check("R3 alloc ignored when full", alloc_tag, 0);
    do_bind(0, 40'h200);
    do_retire();
    check("R11 q_full drops", q_full, 0);
    do_alloc(0);
    check("R11 freed slot reused", alloc_tag, 1);
    check("R11 full again", q_full, 1);
  endtask

  task automatic t_noncoherent();
    do_reset();
    do_alloc(0); do_alloc(1); do_alloc(0);
    do_bind(1, 40'hA000);
    do_bind(0, 40'hB000);
    do_bind(2, 40'hC000);
    do_snoop(40'hC000);
    check("R10 nc bind off head ignored", nuke_valid, 1);
    check("R10 restart tag", nuke_tag, 2);
    do_reset();
    do_alloc(1); do_alloc(0);
    do_bind(0, 40'hD000);
    do_bind(1, 40'hE000);
    do_snoop(40'hE000);
    check("R10 nc bind at head accepted", nuke_valid, 0);
  endtask

  task automatic t_flush();
    do_reset();
    do_alloc(0); do_alloc(0); do_alloc(0); do_alloc(0); do_alloc(0);
    do_flush(2);
    check("R12 tail at flush tag", alloc_tag, 2);
    check("R12 flush raises no restart", nuke_valid, 0);
    do_bind(1, 40'hF000);
    do_snoop(40'hF000);
    check("R12 older load kept", nuke_valid, 1);
    check("R12 restart tag", nuke_tag, 1);
  endtask

  initial begin
    t_reset();
    t_basic_nuke();
    t_line_miss();
    t_release();
    t_wrap_oldest();
    t_full();
    t_noncoherent();
    t_flush();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule